// File: doc/BRIEF.md
# Serial Port Interrupt Arbiter

This block is the interrupt logic of a serial communications element. It collects four interrupt conditions: a line-status error, received data or a character timeout, an empty transmit holding register, and a modem-status change. It keeps a pending flag for each one and masks the flags with a host-written enable register. It reports the most urgent enabled condition through an identification register that the host can read. A single active-high interrupt line tells the host that at least one enabled condition is waiting.

The host clears each condition by servicing it. Reading the line-status, receive-buffer or modem-status register clears the matching flag. The transmit-empty flag clears in either of two ways: the host writes the holding register, or the host reads the identification register while that flag is the one being reported. The host's bus decoder drives one-cycle strobes for these accesses. The receiver, transmitter and modem logic drive one-cycle event strobes and a level for transmit-empty.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, the identification register reads 0x01 and `irq` is low.
- R2: A write to the enable register stores bits 3:0. Bit 0 enables receive data, bit 1 transmit-empty, bit 2 line status and bit 3 modem status. Bits 7:4 always read back as 0.
- R3: `irq` is high exactly when at least one pending condition has its enable bit set. With bits 3:0 all clear, `irq` stays low and the identification register reads 0x01 even if conditions are pending.
- R4: The identification register reports the highest-priority enabled pending condition. Priority runs line status, then receive data, then transmit-empty, then modem status. Bits 2:0 read 3'b110, 3'b100, 3'b010 and 3'b000 respectively.
- R5: Identification bit 0 is 0 when a condition is reported and 1 when none is, so the register reads 0x01 when idle. Bits 7:3 always read 0.
- R6: A line-status read clears the line flag, a receive-buffer read clears the receive flag, and a modem-status read clears the modem flag. Each takes effect on the next cycle.
- R7: The transmit-empty flag is set when `tx_hold_empty` rises, and it is cleared by a holding-register write.
- R8: A read of the identification register clears the transmit-empty flag only if that read returned code 3'b010. Otherwise the flag is untouched.
- R9: The identification value is presented during the read cycle itself, taken from the state before the read. A flag cleared by that read disappears from the next cycle on.
- R10: Writing the enable register with bit 1 newly set, while `tx_hold_empty` is high, makes transmit-empty pending on the next cycle, with no edge on `tx_hold_empty` needed.
- R11: When a set event and a clearing access hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_rdata | output | 8 | Enable register read value |
| iir_rd | input | 1 | Identification register read strobe |
| iir_rdata | output | 8 | Identification register read value |
| lsr_rd | input | 1 | Line-status register read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| msr_rd | input | 1 | Modem-status register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| line_evt | input | 1 | Line-status error event strobe |
| rx_evt | input | 1 | Received data or character timeout event strobe |
| modem_evt | input | 1 | Modem-status change event strobe |
| tx_hold_empty | input | 1 | Transmit holding register empty level |
| irq | output | 1 | Interrupt request, active high |

## Verification
A flag that is latched wrongly shows up at the ports one cycle after the event or access that caused it. It appears as a wrong three-bit code in the identification register, or as `irq` disagreeing with the enabled pending set. A stuck transmit-empty flag, or one cleared by the wrong read, is caught only by a read made after a higher-priority flag has been serviced. The bench therefore retires the conditions one at a time and reads the code after each step. A lost enable-edge set of transmit-empty shows up on the cycle right after the enable write.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int unsigned REG_W  = 8;
    localparam int unsigned SRC_N  = 4;

    // enable register bit positions (decoded by the host)
    localparam int unsigned EN_RXD   = 0;
    localparam int unsigned EN_THRE  = 1;
    localparam int unsigned EN_LINE  = 2;
    localparam int unsigned EN_MODEM = 3;

    localparam logic [REG_W-1:0] IER_MASK = REG_W'((1 << SRC_N) - 1);

    typedef enum logic [2:0] {
        IID_MODEM = 3'b000,
        IID_NONE  = 3'b001,
        IID_THRE  = 3'b010,
        IID_RXD   = 3'b100,
        IID_LINE  = 3'b110
    } iid_e;

endpackage

// File: rtl/uart_irq_src.sv
module uart_irq_src (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;   // a fresh event wins over a service access
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] req_i,
    output iid_e             iid_o
);
    always_comb begin
        if (req_i[EN_LINE])       iid_o = IID_LINE;
        else if (req_i[EN_RXD])   iid_o = IID_RXD;
        else if (req_i[EN_THRE])  iid_o = IID_THRE;
        else if (req_i[EN_MODEM]) iid_o = IID_MODEM;
        else                      iid_o = IID_NONE;
    end

    p_line_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_i[EN_LINE] |-> (iid_o == IID_LINE));
    p_modem_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (iid_o == IID_MODEM) |-> ($countones(req_i) == 1));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ier_wr,
    input  logic [7:0] ier_wdata,
    output logic [7:0] ier_rdata,
    input  logic       iir_rd,
    output logic [7:0] iir_rdata,
    input  logic       lsr_rd,
    input  logic       rbr_rd,
    input  logic       msr_rd,
    input  logic       thr_wr,
    input  logic       line_evt,
    input  logic       rx_evt,
    input  logic       modem_evt,
    input  logic       tx_hold_empty,
    output logic       irq
);
    localparam int unsigned STB_N = 3;   // strobe-set sources: rx, line, modem

    typedef struct packed {
        logic [REG_W-1:0] ier;
        logic             thre;
        logic             tx_prev;
    } state_t;

    state_t s_d, s_q;
    iid_e   iid;
    logic [SRC_N-1:0] pend, req;
    logic [STB_N-1:0] stb_set, stb_clr, stb_flag;

    // strobe-driven sources share one latch shape
    assign stb_set = {modem_evt, line_evt, rx_evt};
    assign stb_clr = {msr_rd,    lsr_rd,   rbr_rd};

    generate
        for (genvar g = 0; g < STB_N; g++) begin : g_src
            uart_irq_src u_src (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (stb_set[g]),
                .clr_i  (stb_clr[g]),
                .flag_o (stb_flag[g])
            );
        end
    endgenerate

    always_comb begin
        pend           = '0;
        pend[EN_RXD]   = stb_flag[0];
        pend[EN_LINE]  = stb_flag[1];
        pend[EN_MODEM] = stb_flag[2];
        pend[EN_THRE]  = s_q.thre;
        req            = pend & s_q.ier[SRC_N-1:0];
    end

    uart_irq_prio u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req),
        .iid_o (iid)
    );

    always_comb begin
        s_d         = s_q;
        s_d.tx_prev = tx_hold_empty;
        if (ier_wr) s_d.ier = ier_wdata & IER_MASK;
        if (thr_wr) s_d.thre = 1'b0;
        if (iir_rd && iid == IID_THRE) s_d.thre = 1'b0;
        if (tx_hold_empty && !s_q.tx_prev) s_d.thre = 1'b1;
        if (ier_wr && ier_wdata[EN_THRE] && !s_q.ier[EN_THRE] && tx_hold_empty)
            s_d.thre = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ier_rdata = s_q.ier;
    assign iir_rdata = {{(REG_W-3){1'b0}}, iid};
    assign irq       = |req;

    p_ier_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ier_rdata[7:4] == 4'h0);
    p_all_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_rdata[3:0] == 4'h0) |-> !irq);
    p_pend_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !iir_rdata[0]);
    p_iir_hi_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        iir_rdata[7:3] == 5'h00);
    p_iir_clears_thre_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && iir_rdata[2:0] == 3'b010 && !tx_hold_empty && !ier_wr) |=> !s_q.thre);
    p_enable_thre_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_wr && ier_wdata[EN_THRE] && !ier_rdata[EN_THRE] && tx_hold_empty) |=> irq);
endmodule

// File: tb/sim_uart_irq_ctrl.sv
`timescale 1ns/1ps
module sim_uart_irq_ctrl;
    logic clk = 1'b0, rst_n = 1'b0;
    logic ier_wr = 0, iir_rd = 0, lsr_rd = 0, rbr_rd = 0, msr_rd = 0, thr_wr = 0;
    logic line_evt = 0, rx_evt = 0, modem_evt = 0, tx_hold_empty = 0;
    logic [7:0] ier_wdata = 0, ier_rdata, iir_rdata;
    logic irq;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    uart_irq_ctrl u0 (.*);

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ier(logic [7:0] v);
        ier_wr = 1; ier_wdata = v; tick(); ier_wr = 0;
    endtask

    task automatic t_reset();
        chk("R1 ier", ier_rdata, 8'h00);
        chk("R1 iir", iir_rdata, 8'h01);
        chk("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_enable_reg();
        wr_ier(8'hFF); chk("R2 ff", ier_rdata, 8'h0F);
        wr_ier(8'hA5); chk("R2 a5", ier_rdata, 8'h05);
        wr_ier(8'h00);
    endtask

    task automatic t_mask();
        line_evt = 1; rx_evt = 1; modem_evt = 1; tick();
        line_evt = 0; rx_evt = 0; modem_evt = 0; tick();
        chk("R3 masked irq", {7'd0, irq}, 8'h00);
        chk("R3 masked iir", iir_rdata, 8'h01);
        wr_ier(8'h0F);
        chk("R3 enabled irq", {7'd0, irq}, 8'h01);
        chk("R4 line top", iir_rdata, 8'h06);
    endtask

    task automatic t_priority();
        tx_hold_empty = 1; tick();              // R7 rise sets transmit-empty
        lsr_rd = 1; tick(); lsr_rd = 0;
        chk("R6 line cleared, R4 rx next", iir_rdata, 8'h04);
        rbr_rd = 1; tick(); rbr_rd = 0;
        chk("R4 thre next", iir_rdata, 8'h02);
        thr_wr = 1; tick(); thr_wr = 0;
        chk("R7 thr write clears", iir_rdata, 8'h00);
        msr_rd = 1; tick(); msr_rd = 0;
        chk("R6 modem cleared R5", iir_rdata, 8'h01);
        chk("R3 irq low", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_iir_read();
        tx_hold_empty = 0; tick();
        tx_hold_empty = 1; modem_evt = 1; tick(); modem_evt = 0;
        chk("R4 thre over modem", iir_rdata, 8'h02);
        iir_rd = 1; #1;
        chk("R9 value during read", iir_rdata, 8'h02);
        tick(); iir_rd = 0;
        chk("R8 thre cleared by read", iir_rdata, 8'h00);
        iir_rd = 1; tick(); iir_rd = 0;
        chk("R8 modem kept", iir_rdata, 8'h00);
        msr_rd = 1; tick(); msr_rd = 0;
        // thre + line pending, read reports line: thre must survive
        tx_hold_empty = 0; tick();
        tx_hold_empty = 1; line_evt = 1; tick(); line_evt = 0;
        iir_rd = 1; tick(); iir_rd = 0;
        chk("R8 line reported", iir_rdata, 8'h06);
        lsr_rd = 1; tick(); lsr_rd = 0;
        chk("R8 thre untouched", iir_rdata, 8'h02);
        thr_wr = 1; tick(); thr_wr = 0;
    endtask

    task automatic t_enable_thre();
        wr_ier(8'h00);
        chk("R10 idle", iir_rdata, 8'h01);
        wr_ier(8'h02);                          // tx_hold_empty still high
        chk("R10 iir", iir_rdata, 8'h02);
        chk("R10 irq", {7'd0, irq}, 8'h01);
        thr_wr = 1; tick(); thr_wr = 0;
        wr_ier(8'h0F);
    endtask

    task automatic t_set_wins();
        line_evt = 1; lsr_rd = 1; tick(); line_evt = 0; lsr_rd = 0;
        chk("R11 line kept", iir_rdata, 8'h06);
        lsr_rd = 1; tick(); lsr_rd = 0;
        chk("R6 line gone", iir_rdata, 8'h01);
    endtask

    initial begin
        fork
            begin
                #3; tick(); tick();
                rst_n = 1; tick();
                t_reset();
                t_enable_reg();
                t_mask();
                t_priority();
                t_iir_read();
                t_enable_thre();
                t_set_wins();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule